// File: doc/BRIEF.md
# Ethernet Pause Flow-Control Register

This block is the host-facing flow-control control word of an Ethernet MAC. It is a single 32-bit register. The lower half is an ordinary pause-length field. The upper half works as a command word: each byte carries a value bit, and a write changes only the bits of that byte whose written data is 1, loading each of them with the byte's value bit. Through this word the host sets the force and advertisement bits, selects fixed-length or on/off pause frames, and issues the flow-control command.

From the register state and the duplex input, the block does four things. It raises pause-frame requests to the transmit path, each with a 16-bit request operand, on a valid/ready handshake with one spare slot. It drives the half-duplex back-pressure output. It resolves the effective transmit and receive pause enables from the force bits and the negotiated results. It passes the pause-ability advertisement bits on to the PHY. A self-clearing change flag guards each pause-length update: the new length reaches the MAC only after the MAC acknowledges it, and until then pause operands use the previously latched length.

Top module: `pause_ctl_reg`

## Requirements
- R1: After the active-low reset, `rd_data` is 0. `preq_valid`, `backpressure`, `tx_pause_en` (with negotiated inputs low), `rx_pause_en`, `adv_pause`, `adv_asym`, `len_upd_req` and `active_len` are all 0.
- R2: A write with `wr_half[1]` set treats bit 23 as the value bit for bits 22:16 and bit 31 as the value bit for bits 30:24. Each bit in those ranges whose written data is 1 takes the value bit. Every other bit keeps its value.
- R3: Bits 31, 29:24, 23 and 17 always read 0, and writes aimed at them have no visible effect.
- R4: A write with `wr_half[0]` set loads bits 15:0 (pause length) directly from `wr_data[15:0]`. This value is shown on `len_new`.
- R5: Bit 30 (change flag, on `len_upd_req`) can only be set by the host; writing 0 to it has no effect. When `len_ack` is high while the flag is 1, `active_len` takes the pause length at that edge, and the flag clears one edge later. `active_len` changes at no other time.
- R6: In full duplex with bit 18 (fixed-length mode) equal to 1 after the write, writing 1 to bit 16 (command) requests one pause frame whose operand is `active_len`. In this mode bit 16 reads 0.
- R7: In full duplex with bit 18 equal to 0, bit 16 is read-write. A 0-to-1 change requests a frame with operand 16'hFFFF, a 1-to-0 change requests 16'h0000, and rewriting the same value requests nothing.
- R8: In half duplex (`full_duplex`=0), bit 16 is read-write and drives `backpressure`, and no pause request is made. In full duplex, `backpressure` is 0.
- R9: `tx_pause_en` is bit 22 ORed with `neg_tx_pause`. `rx_pause_en` is bit 21 ORed with `neg_rx_pause`.
- R10: `adv_asym` follows bit 20 and `adv_pause` follows bit 19.
- R11: Once `preq_valid` is raised, it and `preq_operand` stay unchanged until a cycle with `preq_ready` high.
- R12: A request made while one is waiting goes into a single spare slot, and the newest such request replaces the older one. After each handshake, the slot's request is presented next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_half | input | 2 | Half enables: [1] upper command half, [0] pause length |
| wr_data | input | 32 | Host write data |
| rd_data | output | 32 | Register read-back value |
| full_duplex | input | 1 | Link duplex: 1 full, 0 half |
| neg_tx_pause | input | 1 | Negotiated transmit-pause result |
| neg_rx_pause | input | 1 | Negotiated receive-pause result |
| tx_pause_en | output | 1 | Effective transmit-pause enable |
| rx_pause_en | output | 1 | Effective receive-pause enable |
| adv_pause | output | 1 | Pause-ability advertisement bit |
| adv_asym | output | 1 | Asymmetric-pause advertisement bit |
| backpressure | output | 1 | Half-duplex back-pressure request |
| preq_valid | output | 1 | Pause-frame request valid |
| preq_operand | output | LEN_W | Request operand of the pending pause frame |
| preq_ready | input | 1 | Transmit side accepts the request |
| len_upd_req | output | 1 | Pause-length change pending (bit 30) |
| len_new | output | LEN_W | Pause length as written by the host |
| len_ack | input | 1 | MAC acknowledges the new pause length |
| active_len | output | LEN_W | Pause length in use for fixed-length operands |

## Verification
The bench builds the block with its default `LEN_W` of 16. That width matches the register's 16-bit length field and gives the all-ones operand of 16'hFFFF. So the read-back layout, the masked byte writes, the three command modes and the length handshake are all visible at full width. The short directed sequences reach the spare-slot overwrite, the no-op rewrite of an unchanged command bit, the writes to reserved bits, and the one-edge lag between acknowledge and flag clear.

// File: rtl/pause_ctl_reg.sv
module pause_ctl_reg #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_half,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data,
  input  logic             full_duplex,
  input  logic             neg_tx_pause,
  input  logic             neg_rx_pause,
  output logic             tx_pause_en,
  output logic             rx_pause_en,
  output logic             adv_pause,
  output logic             adv_asym,
  output logic             backpressure,
  output logic             preq_valid,
  output logic [LEN_W-1:0] preq_operand,
  input  logic             preq_ready,
  output logic             len_upd_req,
  output logic [LEN_W-1:0] len_new,
  input  logic             len_ack,
  output logic [LEN_W-1:0] active_len
);

  localparam int HW = 16;
  localparam logic [HW-1:0] HI_IMPL = 16'b0100_0000_0111_1101;
  localparam int B_CMD  = 0;
  localparam int B_FIX  = 2;
  localparam int B_APA  = 3;
  localparam int B_AAS  = 4;
  localparam int B_FRX  = 5;
  localparam int B_FTX  = 6;
  localparam int B_CHG  = 14;
  localparam logic [LEN_W-1:0] OP_ONES = {LEN_W{1'b1}};

  logic [HW-1:0]    hi_q, hi_wr, hi_new, hi_d;
  logic [LEN_W-1:0] plen_q, lat_q;
  logic             ack_seen;
  logic             upd_hi, upd_lo, fix_next, cmd_touch, cmd_val, fixed_cmd;
  logic             new_req;
  logic [LEN_W-1:0] new_op;
  logic             slot_v;
  logic [LEN_W-1:0] slot_op;
  logic             take;

  assign upd_hi = wr_en && wr_half[1];
  assign upd_lo = wr_en && wr_half[0];

  for (genvar i = 0; i < HW; i++) begin : g_hi
    localparam int VB = (i < 8) ? 7 : 15;
    if (i == VB) begin : g_val
      assign hi_wr[i] = 1'b0;
    end else begin : g_fld
      assign hi_wr[i] = wr_data[HW+i] ? wr_data[HW+VB] : hi_q[i];
    end
  end

  assign hi_new    = hi_wr & HI_IMPL;
  assign fix_next  = upd_hi ? hi_new[B_FIX] : hi_q[B_FIX];
  assign cmd_touch = upd_hi && wr_data[HW+B_CMD];
  assign cmd_val   = wr_data[HW+7];
  assign fixed_cmd = cmd_touch && full_duplex && fix_next;

  assign new_req = cmd_touch && full_duplex &&
                   (fix_next ? cmd_val : (cmd_val != hi_q[B_CMD]));
  assign new_op  = fix_next ? lat_q : (cmd_val ? OP_ONES : '0);

  always_comb begin
    hi_d = upd_hi ? hi_new : hi_q;
    hi_d[B_CHG] = hi_q[B_CHG] || (upd_hi && hi_new[B_CHG]);
    if (fixed_cmd) hi_d[B_CMD] = 1'b0;
    if (ack_seen)  hi_d[B_CHG] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q     <= '0;
      plen_q   <= '0;
      lat_q    <= '0;
      ack_seen <= 1'b0;
    end else begin
      hi_q     <= hi_d;
      ack_seen <= len_ack && hi_q[B_CHG];
      if (upd_lo) plen_q <= wr_data[LEN_W-1:0];
      if (len_ack && hi_q[B_CHG]) lat_q <= plen_q;
    end
  end

  assign take = preq_valid && preq_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preq_valid   <= 1'b0;
      preq_operand <= '0;
      slot_v       <= 1'b0;
      slot_op      <= '0;
    end else if (!preq_valid) begin
      if (new_req) begin
        preq_valid   <= 1'b1;
        preq_operand <= new_op;
      end
    end else if (take) begin
      if (slot_v) begin
        preq_operand <= slot_op;
        slot_v       <= new_req;
        if (new_req) slot_op <= new_op;
      end else if (new_req) begin
        preq_operand <= new_op;
      end else begin
        preq_valid <= 1'b0;
      end
    end else if (new_req) begin
      slot_v  <= 1'b1;
      slot_op <= new_op;
    end
  end

  assign rd_data = {hi_q[HW-1:1],
                    hi_q[B_CMD] && !(full_duplex && hi_q[B_FIX]),
                    HW'(plen_q)};

  assign tx_pause_en  = hi_q[B_FTX] || neg_tx_pause;
  assign rx_pause_en  = hi_q[B_FRX] || neg_rx_pause;
  assign adv_pause    = hi_q[B_APA];
  assign adv_asym     = hi_q[B_AAS];
  assign backpressure = hi_q[B_CMD] && !full_duplex;
  assign len_upd_req  = hi_q[B_CHG];
  assign len_new      = plen_q;
  assign active_len   = lat_q;

endmodule

// File: rtl/pause_ctl_reg_chk.sv
module pause_ctl_reg_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             full_duplex,
  input logic             backpressure,
  input logic             neg_tx_pause,
  input logic             neg_rx_pause,
  input logic             tx_pause_en,
  input logic             rx_pause_en,
  input logic             preq_valid,
  input logic             preq_ready,
  input logic [LEN_W-1:0] preq_operand,
  input logic             len_upd_req,
  input logic             len_ack,
  input logic [LEN_W-1:0] len_new,
  input logic [LEN_W-1:0] active_len
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (preq_valid && !preq_ready) |=> (preq_valid && $stable(preq_operand))); // R11

  AST_HALF_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_duplex && !preq_valid) |=> !preq_valid); // R8

  AST_FULL_NO_BP: assert property (@(posedge clk) disable iff (!rst_n)
    full_duplex |-> !backpressure); // R8

  AST_ENABLE_OR: assert property (@(posedge clk) disable iff (!rst_n)
    (neg_tx_pause |-> tx_pause_en) and (neg_rx_pause |-> rx_pause_en)); // R9

  AST_LEN_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (len_upd_req && len_ack) |=> (active_len == $past(len_new))); // R5

  AST_LEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(len_upd_req && len_ack) |=> $stable(active_len)); // R5

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (len_upd_req && len_ack) |=> len_upd_req ##1 !len_upd_req); // R5

endmodule

bind pause_ctl_reg pause_ctl_reg_chk #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/sim_pause_ctl_reg.sv
module sim_pause_ctl_reg;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_half = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic full_duplex = 1'b1, neg_tx_pause = 1'b0, neg_rx_pause = 1'b0;
  logic tx_pause_en, rx_pause_en, adv_pause, adv_asym, backpressure;
  logic preq_valid, preq_ready = 1'b0;
  logic [LEN_W-1:0] preq_operand, len_new, active_len;
  logic len_upd_req, len_ack = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pause_ctl_reg #(.LEN_W(LEN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_half(wr_half), .wr_data(wr_data),
    .rd_data(rd_data), .full_duplex(full_duplex), .neg_tx_pause(neg_tx_pause),
    .neg_rx_pause(neg_rx_pause), .tx_pause_en(tx_pause_en), .rx_pause_en(rx_pause_en),
    .adv_pause(adv_pause), .adv_asym(adv_asym), .backpressure(backpressure),
    .preq_valid(preq_valid), .preq_operand(preq_operand), .preq_ready(preq_ready),
    .len_upd_req(len_upd_req), .len_new(len_new), .len_ack(len_ack),
    .active_len(active_len));

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] half, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_half = half; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0; wr_half = '0; wr_data = '0;
  endtask

  task automatic accept();
    @(negedge clk); preq_ready = 1'b1;
    @(posedge clk); #1; preq_ready = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    check("R1", "rd_data", rd_data, 32'h0);
    check("R1", "outputs", {preq_valid, backpressure, tx_pause_en, rx_pause_en,
                            adv_pause, adv_asym, len_upd_req}, '0);
    check("R1", "active_len", 32'(active_len), 32'h0);
  endtask

  task automatic t_masks();
    wr(2'b10, 32'h0098_0000);
    check("R2", "rd after set 20,19", rd_data, 32'h0018_0000);
    check("R10", "adv asym/pause", {adv_asym, adv_pause}, 2'b11);
    wr(2'b10, 32'h0008_0000);
    check("R2", "rd after clear 19", rd_data, 32'h0010_0000);
    check("R10", "adv asym/pause", {adv_asym, adv_pause}, 2'b10);
    wr(2'b10, 32'hBF82_0000);
    check("R3", "reserved writes", rd_data, 32'h0010_0000);
  endtask

  task automatic t_len();
    wr(2'b01, 32'h0000_1234);
    check("R4", "rd length", rd_data, 32'h0010_1234);
    check("R4", "len_new", 32'(len_new), 32'h1234);
    check("R5", "active_len untouched", 32'(active_len), 32'h0);
  endtask

  task automatic t_chg();
    wr(2'b11, 32'hC000_0A0B);
    check("R5", "rd flag set", rd_data, 32'h4010_0A0B);
    idle(2);
    check("R5", "flag waits for ack", 32'(len_upd_req), 32'h1);
    check("R5", "old length in use", 32'(active_len), 32'h0);
    wr(2'b10, 32'h4000_0000);
    check("R5", "writing 0 to flag ignored", 32'(len_upd_req), 32'h1);
    @(negedge clk); len_ack = 1'b1;
    @(posedge clk); #1; len_ack = 1'b0;
    check("R5", "length taken at ack", 32'(active_len), 32'h0A0B);
    check("R5", "flag still set one edge", 32'(len_upd_req), 32'h1);
    idle(1);
    check("R5", "flag cleared", rd_data, 32'h0010_0A0B);
  endtask

  task automatic t_fixp();
    full_duplex = 1'b1;
    wr(2'b10, 32'h0085_0000);
    check("R6", "request valid", 32'(preq_valid), 32'h1);
    check("R6", "operand is length", 32'(preq_operand), 32'h0A0B);
    check("R6", "cmd reads 0", rd_data, 32'h0014_0A0B);
    idle(2);
    check("R11", "held valid/operand", {15'h0, preq_valid, preq_operand}, 32'h0001_0A0B);
    accept();
    check("R11", "valid drops after ready", 32'(preq_valid), 32'h0);
  endtask

  task automatic t_toggle();
    wr(2'b10, 32'h0004_0000);
    check("R7", "no request on fixp clear", 32'(preq_valid), 32'h0);
    wr(2'b10, 32'h0081_0000);
    check("R7", "rise operand", {15'h0, preq_valid, preq_operand}, 32'h0001_FFFF);
    check("R7", "cmd reads 1", rd_data, 32'h0011_0A0B);
    accept();
    wr(2'b10, 32'h0081_0000);
    check("R7", "same value no request", 32'(preq_valid), 32'h0);
    wr(2'b10, 32'h0001_0000);
    check("R7", "fall operand", {15'h0, preq_valid, preq_operand}, 32'h0001_0000);
    check("R7", "cmd reads 0", rd_data, 32'h0010_0A0B);
    accept();
  endtask

  task automatic t_queue();
    wr(2'b10, 32'h0081_0000);
    wr(2'b10, 32'h0001_0000);
    wr(2'b10, 32'h0081_0000);
    check("R12", "head unchanged", {15'h0, preq_valid, preq_operand}, 32'h0001_FFFF);
    accept();
    check("R12", "newest slot presented", {15'h0, preq_valid, preq_operand}, 32'h0001_FFFF);
    accept();
    check("R12", "queue empty", 32'(preq_valid), 32'h0);
    wr(2'b10, 32'h0001_0000);
    check("R12", "clear request", {15'h0, preq_valid, preq_operand}, 32'h0001_0000);
    accept();
  endtask

  task automatic t_half();
    full_duplex = 1'b0;
    wr(2'b10, 32'h0001_0000);
    check("R8", "bp off", 32'(backpressure), 32'h0);
    wr(2'b10, 32'h0081_0000);
    check("R8", "bp on", 32'(backpressure), 32'h1);
    check("R8", "no request", 32'(preq_valid), 32'h0);
    check("R8", "cmd reads 1", rd_data, 32'h0011_0A0B);
    wr(2'b10, 32'h0001_0000);
    check("R8", "bp off again", {backpressure, preq_valid}, 2'b00);
    full_duplex = 1'b1;
  endtask

  task automatic t_enables();
    neg_tx_pause = 1'b1; #1;
    check("R9", "tx by negotiation", {tx_pause_en, rx_pause_en}, 2'b10);
    neg_tx_pause = 1'b0; #1;
    check("R9", "both off", {tx_pause_en, rx_pause_en}, 2'b00);
    wr(2'b10, 32'h00A0_0000);
    check("R9", "rx forced", {tx_pause_en, rx_pause_en}, 2'b01);
    wr(2'b10, 32'h00C0_0000);
    check("R9", "tx forced", {tx_pause_en, rx_pause_en}, 2'b11);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    idle(1);
    t_reset();
    t_masks();
    t_len();
    t_chg();
    t_fixp();
    t_toggle();
    t_queue();
    t_half();
    t_enables();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule